// File: doc/BRIEF.md
# Reset-Pulse-Width Test Mode Selector

This block picks a factory test mode from the width of a low pulse on an active-low pin. The pulse width is counted in cycles of the 33 MHz PCI clock. Power-good must be high before any measurement can happen. The block does nothing more until the platform reset has been released and the pin has been seen high. After that, the first complete low pulse is measured with a saturating counter. The count is decoded when the pin returns high.

A pulse of four to seven cycles selects one of four XOR-chain test modes. Any other width selects no mode, and the block still reports that a decision was made. The decision is latched and presented on an encoded bus and on a one-hot bus. It stays until power-good falls. Later pulses on the pin have no effect. The test logic that a selected mode enables is outside this block.

The pin and the platform reset pass through the same synchronizer. Both are delayed by the same number of cycles, so the measured width equals the width at the pin. All outputs are plain level signals. There is no streaming interface, so no back-pressure applies.

Top module: `tms_selector`

## Requirements
- R1: While `pwr_good` is low, `mode_valid`, `mode_code` and `mode_onehot` are all zero. They clear at once when `pwr_good` falls, without waiting for a clock edge.
- R2: A completed low pulse of 1, 2 or 3 clock cycles sets `mode_valid` to 1 with `mode_code` = 0 and `mode_onehot` = 0 (no test mode).
- R3: A completed low pulse of exactly 4, 5, 6 or 7 cycles sets `mode_code` to 1, 2, 3 or 4. It sets `mode_onehot` bit 0, 1, 2 or 3 respectively, with all other bits clear.
- R4: The length counter saturates. Pulses of 8 or more cycles, including very long ones, give `mode_valid` = 1 with `mode_code` = 0 and `mode_onehot` = 0.
- R5: Low levels on `tm_pin_n` while `plat_rst_n` is low do not start a measurement. This also holds for a low that continues past the release of `plat_rst_n`. The pin must first be seen high with the reset released.
- R6: `mode_valid` rises on the second rising clock edge after the first edge that samples `tm_pin_n` high at the end of the pulse. It stays 0 until then.
- R7: Once `mode_valid` is 1, it and both mode buses hold their values until `pwr_good` falls. Further pulses on `tm_pin_n` are ignored.
- R8: If `plat_rst_n` goes low during a pulse, that pulse is abandoned and produces no result. A later complete pulse after the reset is released is measured normally.
- R9: `mode_onehot` has at most one bit set. It has exactly one bit set when, and only when, `mode_code` is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock, 33 MHz |
| pwr_good | input | 1 | Power-good. Low clears the block asynchronously; high enables selection |
| plat_rst_n | input | 1 | Platform reset, active low. Measurement is armed only while it is high |
| tm_pin_n | input | 1 | Active-low pin whose low-pulse width selects the mode |
| mode_valid | output | 1 | A selection decision has been latched |
| mode_code | output | 3 | Selected chain, 1 to 4; 0 means no test mode |
| mode_onehot | output | 4 | One bit per chain, bit n selects chain n+1 |

## Verification
A fault in the length counter shows up directly at the outputs: an off-by-one or a missing saturation moves a pulse into the neighbouring chain, or into or out of the no-mode band. It is visible two cycles after the pulse ends. A wrong arming state makes a result appear after a pulse that overlapped the platform reset, or lets a second pulse overwrite the first result. Both are visible a few cycles after the pulse that should have been ignored. Latency faults in the synchronizer or the decision path move the rising edge of `mode_valid` by whole cycles, so the bench checks that edge cycle by cycle.

// File: rtl/tms_pkg.sv
package tms_pkg;

  // Pulse meter states
  typedef enum logic [1:0] {
    ST_IDLE,   // waiting for released reset and a high pin
    ST_READY,  // armed, waiting for the falling edge
    ST_COUNT,  // pin low, counting cycles
    ST_DONE    // decision taken, frozen until power-good drops
  } meter_state_e;

endpackage

// File: rtl/tms_sync.sv
module tms_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) begin
        chain_q[k] <= chain_q[k-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tms_pulse_meter.sv
module tms_pulse_meter
  import tms_pkg::*;
#(
  parameter int unsigned SAT_CNT = 8,
  parameter int unsigned CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed_i,   // synchronized platform reset, high = released
  input  logic             pin_i,     // synchronized pin level
  output logic             finish_o,  // one-cycle strobe: pulse completed
  output logic [CNT_W-1:0] len_o      // measured low length, saturated
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SAT_CNT);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  meter_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (armed_i && pin_i) state_d = ST_READY;
      end
      ST_READY: begin
        if (!armed_i) begin
          state_d = ST_IDLE;
        end else if (!pin_i) begin
          state_d = ST_COUNT;
          cnt_d   = CNT_ONE;
        end
      end
      ST_COUNT: begin
        if (!armed_i) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (pin_i) begin
          state_d = ST_DONE;
        end else if (cnt_q != CNT_SAT) begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      ST_DONE: begin
        state_d = ST_DONE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign finish_o = (state_q == ST_COUNT) && armed_i && pin_i;
  assign len_o    = cnt_q;

endmodule

// File: rtl/tms_decode.sv
module tms_decode #(
  parameter int unsigned MIN_LEN    = 4,
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned CODE_W     = 3
) (
  input  logic [CNT_W-1:0]      len_i,
  output logic [CODE_W-1:0]     code_o,
  output logic [NUM_CHAINS-1:0] onehot_o
);

  for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_slot
    assign onehot_o[i] = (len_i == CNT_W'(MIN_LEN + i));
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_CHAINS; i++) begin
      if (onehot_o[i]) code_o = CODE_W'(i + 1);
    end
  end

endmodule

// File: rtl/tms_selector.sv
module tms_selector #(
  parameter int unsigned MIN_LEN     = 4,
  parameter int unsigned NUM_CHAINS  = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SAT_CNT    = MIN_LEN + NUM_CHAINS,
  localparam int unsigned CNT_W      = $clog2(SAT_CNT + 1),
  localparam int unsigned CODE_W     = $clog2(NUM_CHAINS + 1)
) (
  input  logic                  clk,
  input  logic                  pwr_good,
  input  logic                  plat_rst_n,
  input  logic                  tm_pin_n,
  output logic                  mode_valid,
  output logic [CODE_W-1:0]     mode_code,
  output logic [NUM_CHAINS-1:0] mode_onehot
);

  logic [1:0]            sync_q;
  logic                  armed_s;
  logic                  pin_s;
  logic                  finish;
  logic [CNT_W-1:0]      len;
  logic [CODE_W-1:0]     dec_code;
  logic [NUM_CHAINS-1:0] dec_onehot;

  // Pin and reset share one synchronizer so their delays match
  tms_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst_n (pwr_good),
    .d_i   ({plat_rst_n, tm_pin_n}),
    .q_o   (sync_q)
  );

  assign armed_s = sync_q[1];
  assign pin_s   = sync_q[0];

  tms_pulse_meter #(
    .SAT_CNT (SAT_CNT),
    .CNT_W   (CNT_W)
  ) meter_i (
    .clk      (clk),
    .rst_n    (pwr_good),
    .armed_i  (armed_s),
    .pin_i    (pin_s),
    .finish_o (finish),
    .len_o    (len)
  );

  tms_decode #(
    .MIN_LEN    (MIN_LEN),
    .NUM_CHAINS (NUM_CHAINS),
    .CNT_W      (CNT_W),
    .CODE_W     (CODE_W)
  ) decode_i (
    .len_i    (len),
    .code_o   (dec_code),
    .onehot_o (dec_onehot)
  );

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      mode_valid  <= 1'b0;
      mode_code   <= '0;
      mode_onehot <= '0;
    end else if (finish && !mode_valid) begin
      mode_valid  <= 1'b1;
      mode_code   <= dec_code;
      mode_onehot <= dec_onehot;
    end
  end

endmodule

// File: rtl/tms_selector_chk.sv
module tms_selector_chk #(
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned CODE_W     = 3
) (
  input logic                  clk,
  input logic                  pwr_good,
  input logic                  plat_rst_n,
  input logic                  tm_pin_n,
  input logic                  mode_valid,
  input logic [CODE_W-1:0]     mode_code,
  input logic [NUM_CHAINS-1:0] mode_onehot
);

  // R9
  onehot_at_most_one_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $onehot0(mode_onehot));

  // R9
  code_matches_onehot_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (($countones(mode_onehot) == 1) == (mode_code != '0)));

  // R1
  clear_without_decision_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    !mode_valid |-> (mode_code == '0) && (mode_onehot == '0));

  // R7
  result_held_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    mode_valid |=> mode_valid && $stable(mode_code) && $stable(mode_onehot));

  // R6
  valid_after_release_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(mode_valid) |-> $past(tm_pin_n, 2));

  // R5
  no_valid_from_reset_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(mode_valid) |-> $past(plat_rst_n, 2));

endmodule

bind tms_selector tms_selector_chk #(
  .NUM_CHAINS (NUM_CHAINS),
  .CODE_W     (CODE_W)
) chk_i (
  .clk         (clk),
  .pwr_good    (pwr_good),
  .plat_rst_n  (plat_rst_n),
  .tm_pin_n    (tm_pin_n),
  .mode_valid  (mode_valid),
  .mode_code   (mode_code),
  .mode_onehot (mode_onehot)
);

// File: tb/tms_selector_tb_top.sv
`timescale 1ns/1ps
module tms_selector_tb_top;

  localparam int CLK_PERIOD = 30;
  localparam int NVEC       = 10;
  localparam int unsigned VEC_LEN  [NVEC] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 20};
  localparam int unsigned VEC_CODE [NVEC] = '{0, 0, 0, 1, 2, 3, 4, 0, 0, 0};

  logic       clk = 1'b0;
  logic       pwr_good = 1'b0;
  logic       plat_rst_n = 1'b0;
  logic       tm_pin_n = 1'b1;
  logic       mode_valid;
  logic [2:0] mode_code;
  logic [3:0] mode_onehot;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tms_selector dut_i (
    .clk         (clk),
    .pwr_good    (pwr_good),
    .plat_rst_n  (plat_rst_n),
    .tm_pin_n    (tm_pin_n),
    .mode_valid  (mode_valid),
    .mode_code   (mode_code),
    .mode_onehot (mode_onehot)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_result(input string req, input int vld, input int code);
    int oh;
    oh = (code == 0) ? 0 : (1 << (code - 1));
    chk(req, "valid", int'(mode_valid), vld);
    chk(req, "code", int'(mode_code), code);
    chk(req, "onehot", int'(mode_onehot), oh);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Full power cycle, then release the platform reset and let it settle
  task automatic power_up();
    @(negedge clk);
    pwr_good = 1'b0; plat_rst_n = 1'b0; tm_pin_n = 1'b1;
    repeat (2) @(negedge clk);
    pwr_good = 1'b1;
    repeat (2) @(negedge clk);
    plat_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Pin low for exactly len rising edges; returns at the negedge before the first high edge
  task automatic pulse(input int len);
    tm_pin_n = 1'b0;
    repeat (len) @(negedge clk);
    tm_pin_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: outputs clear while power-good is low
    repeat (3) @(negedge clk);
    chk_result("R1", 0, 0);

    // Table of pulse widths: R2 short, R3 chains, R4 saturated long
    for (int v = 0; v < NVEC; v++) begin
      string req;
      req = (VEC_LEN[v] < 4) ? "R2" : ((VEC_LEN[v] <= 7) ? "R3" : "R4");
      power_up();
      chk_result(req, 0, 0);
      pulse(int'(VEC_LEN[v]));
      repeat (6) @(negedge clk);
      chk_result(req, 1, int'(VEC_CODE[v]));
    end

    // R6: exact latency of the valid flag
    power_up();
    pulse(4);
    @(negedge clk);
    chk("R6", "valid after first high edge", int'(mode_valid), 0);
    @(negedge clk);
    chk("R6", "valid after second high edge", int'(mode_valid), 0);
    @(negedge clk);
    chk("R6", "valid after third high edge", int'(mode_valid), 1);
    chk("R6", "code", int'(mode_code), 1);

    // R7: later pulses ignored, result holds
    pulse(6);
    repeat (6) @(negedge clk);
    chk_result("R7", 1, 1);
    pulse(20);
    repeat (6) @(negedge clk);
    chk_result("R7", 1, 1);

    // R1: power-good drop clears at once, without a clock edge
    #(CLK_PERIOD/4);
    pwr_good = 1'b0;
    #1;
    chk_result("R1", 0, 0);

    // R5: low during platform reset, continuing past its release
    @(negedge clk);
    pwr_good = 1'b0; plat_rst_n = 1'b0; tm_pin_n = 1'b1;
    repeat (2) @(negedge clk);
    pwr_good = 1'b1;
    @(negedge clk);
    pulse(5);
    repeat (3) @(negedge clk);
    tm_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    plat_rst_n = 1'b1;
    repeat (5) @(negedge clk);
    tm_pin_n = 1'b1;
    repeat (8) @(negedge clk);
    chk_result("R5", 0, 0);
    pulse(6);
    repeat (6) @(negedge clk);
    chk_result("R5", 1, 3);

    // R8: platform reset during a pulse abandons it
    power_up();
    tm_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    plat_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    tm_pin_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_result("R8", 0, 0);
    plat_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pulse(7);
    repeat (6) @(negedge clk);
    chk_result("R8", 1, 4);

    // R9: one-hot and code agree on every chain
    for (int c = 1; c <= 4; c++) begin
      power_up();
      pulse(3 + c);
      repeat (6) @(negedge clk);
      chk("R9", "onehot vs code", int'(mode_onehot), 1 << (int'(mode_code) - 1));
    end

    finish_run();
  end

endmodule